// File: doc/BRIEF.md
# Function Unit Issue/Execute Handshake

This block is the control for one function unit. It sits between the scoreboard, which hands out grants, and the compute datapath, which raises requests. An issue strobe accepted while the unit is free makes it busy. The strobe also latches the source register addresses and raises a read request. When the read grant arrives, the block drives the enable and address inputs of a synchronous register file in that same cycle. Exactly one cycle later it emits an execute strobe, and the operands returned by the file are captured on that strobe.

After the execute phase the block raises a write request. By default the execute phase is zero extra cycles, so the write request rises straight after the strobe. The parameter `EXEC_CYC` inserts a counted execute stage instead. The write request is held until the write grant, and then the unit is free again. Every request output is produced here, and every grant is an input from the scoreboard side.

Top module: `fu_handshake`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `busy_o`, `rd_req_o`, `go_exec_o`, `wr_req_o` and `rf_rd_en_o` all low.
- R2: An `issue_i` sampled while `busy_o` is low makes `busy_o` and `rd_req_o` high in the following cycle.
- R3: An `issue_i` sampled while `busy_o` is high is ignored. This includes the cycle in which the write grant is taken. The latched source addresses stay unchanged, and no new read request appears after the unit frees.
- R4: `rd_req_o` stays high until a cycle with `go_rd_i` high. A `go_rd_i` seen while `rd_req_o` is low has no effect.
- R5: In a cycle with `rd_req_o` and `go_rd_i` both high, `rf_rd_en_o` is high in that same cycle. `rf_rd_addr_o` then carries the addresses latched at issue, with operand k in bits [k*AW +: AW].
- R6: `go_exec_o` is high for exactly one cycle, namely the cycle right after an accepted read grant.
- R7: `opnd_o` takes the value of `rf_rd_data_i` present in the `go_exec_o` cycle, from the next cycle on. It holds that value until the next execute strobe.
- R8: With `EXEC_CYC` = 0, `wr_req_o` rises in the cycle after `go_exec_o`. It stays high until a cycle with `go_wr_i` high.
- R9: A `go_wr_i` taken while `wr_req_o` is high makes `wr_req_o` and `busy_o` low in the next cycle. A `go_wr_i` seen while `wr_req_o` is low has no effect.
- R10: At most one of `rd_req_o`, `go_exec_o` and `wr_req_o` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_i | input | 1 | Issue strobe from the scoreboard |
| src_addr_i | input | NSRC*AW | Source register addresses, sampled on an accepted issue |
| busy_o | output | 1 | Unit holds an operation |
| rd_req_o | output | 1 | Read request to the scoreboard |
| go_rd_i | input | 1 | Read grant |
| rf_rd_en_o | output | 1 | Register file read enable |
| rf_rd_addr_o | output | NSRC*AW | Register file read addresses |
| rf_rd_data_i | input | NSRC*DW | Register file data, valid one cycle after enable |
| go_exec_o | output | 1 | Execute strobe |
| opnd_o | output | NSRC*DW | Captured operands |
| wr_req_o | output | 1 | Write request to the scoreboard |
| go_wr_i | input | 1 | Write grant |

## Verification
The one real collision is a fresh issue strobe arriving in the same cycle as the write grant that frees the unit. The bench provokes it by raising `issue_i` together with `go_wr_i`, using addresses that differ from the running operation. It then confirms that `busy_o` and `rd_req_o` both fall in the next cycle, and that the addresses are not overwritten. It also raises both grants while the unit is idle, and checks that the read enable stays low and that no request appears.

// File: rtl/fu_hs_pkg.sv
package fu_hs_pkg;

   typedef enum logic [2:0] {
      FU_IDLE  = 3'd0,
      FU_RDREQ = 3'd1,
      FU_EXEC  = 3'd2,
      FU_RUN   = 3'd3,
      FU_WRREQ = 3'd4
   } fu_state_e;

   function automatic int unsigned cnt_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/fu_hs_exec.sv
module fu_hs_exec #(
   parameter int unsigned EXEC_CYC = 0
) (
   input  logic clk,
   input  logic rst,
   input  logic start_i,
   output logic done_o
);
   localparam int unsigned CW = fu_hs_pkg::cnt_width(EXEC_CYC);

   generate
      if (EXEC_CYC == 0) begin : g_direct
         assign done_o = start_i;
      end else begin : g_count
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (rst)
               cnt_q <= '0;
            else if (start_i)
               cnt_q <= CW'(EXEC_CYC);
            else if (cnt_q != '0)
               cnt_q <= cnt_q - 1'b1;
         end
         assign done_o = (cnt_q == CW'(1));
      end
   endgenerate
endmodule

// File: rtl/fu_hs_seq.sv
module fu_hs_seq
   import fu_hs_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic issue_i,
   input  logic go_rd_i,
   input  logic exec_done_i,
   input  logic go_wr_i,
   output logic issue_acc_o,
   output logic rd_acc_o,
   output logic busy_o,
   output logic rd_req_o,
   output logic go_exec_o,
   output logic wr_req_o
);
   fu_state_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         FU_IDLE:  if (issue_i) st_d = FU_RDREQ;
         FU_RDREQ: if (go_rd_i) st_d = FU_EXEC;
         FU_EXEC:  st_d = exec_done_i ? FU_WRREQ : FU_RUN;
         FU_RUN:   if (exec_done_i) st_d = FU_WRREQ;
         FU_WRREQ: if (go_wr_i) st_d = FU_IDLE;
         default:  st_d = FU_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) st_q <= FU_IDLE;
      else     st_q <= st_d;
   end

   assign busy_o      = (st_q != FU_IDLE);
   assign rd_req_o    = (st_q == FU_RDREQ);
   assign go_exec_o   = (st_q == FU_EXEC);
   assign wr_req_o    = (st_q == FU_WRREQ);
   assign issue_acc_o = issue_i && (st_q == FU_IDLE);
   assign rd_acc_o    = go_rd_i && (st_q == FU_RDREQ);
endmodule

// File: rtl/fu_hs_lane.sv
module fu_hs_lane #(
   parameter int unsigned AW = 5,
   parameter int unsigned DW = 32
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          load_i,
   input  logic [AW-1:0] addr_i,
   input  logic          cap_i,
   input  logic [DW-1:0] data_i,
   output logic [AW-1:0] addr_o,
   output logic [DW-1:0] data_o
);
   always_ff @(posedge clk) begin
      if (rst) begin
         addr_o <= '0;
         data_o <= '0;
      end else begin
         if (load_i) addr_o <= addr_i;
         if (cap_i)  data_o <= data_i;
      end
   end
endmodule

// File: rtl/fu_handshake.sv
module fu_handshake #(
   parameter int unsigned NSRC     = 2,
   parameter int unsigned AW       = 5,
   parameter int unsigned DW       = 32,
   parameter int unsigned EXEC_CYC = 0
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               issue_i,
   input  logic [NSRC*AW-1:0] src_addr_i,
   output logic               busy_o,
   output logic               rd_req_o,
   input  logic               go_rd_i,
   output logic               rf_rd_en_o,
   output logic [NSRC*AW-1:0] rf_rd_addr_o,
   input  logic [NSRC*DW-1:0] rf_rd_data_i,
   output logic               go_exec_o,
   output logic [NSRC*DW-1:0] opnd_o,
   output logic               wr_req_o,
   input  logic               go_wr_i
);
   generate
      if (NSRC < 1 || NSRC > 8) begin : g_bad_nsrc
         $error("fu_handshake: NSRC out of range");
      end
      if (AW < 1 || AW > 12) begin : g_bad_aw
         $error("fu_handshake: AW out of range");
      end
      if (DW < 1) begin : g_bad_dw
         $error("fu_handshake: DW must be positive");
      end
   endgenerate

   logic issue_acc;
   logic rd_acc;
   logic exec_done;

   fu_hs_seq u_seq (
      .clk         (clk),
      .rst         (rst),
      .issue_i     (issue_i),
      .go_rd_i     (go_rd_i),
      .exec_done_i (exec_done),
      .go_wr_i     (go_wr_i),
      .issue_acc_o (issue_acc),
      .rd_acc_o    (rd_acc),
      .busy_o      (busy_o),
      .rd_req_o    (rd_req_o),
      .go_exec_o   (go_exec_o),
      .wr_req_o    (wr_req_o)
   );

   fu_hs_exec #(.EXEC_CYC(EXEC_CYC)) u_exec (
      .clk     (clk),
      .rst     (rst),
      .start_i (go_exec_o),
      .done_o  (exec_done)
   );

   assign rf_rd_en_o = rd_acc;

   for (genvar k = 0; k < NSRC; k++) begin : g_lane
      fu_hs_lane #(.AW(AW), .DW(DW)) u_lane (
         .clk    (clk),
         .rst    (rst),
         .load_i (issue_acc),
         .addr_i (src_addr_i[k*AW +: AW]),
         .cap_i  (go_exec_o),
         .data_i (rf_rd_data_i[k*DW +: DW]),
         .addr_o (rf_rd_addr_o[k*AW +: AW]),
         .data_o (opnd_o[k*DW +: DW])
      );
   end
endmodule

// File: rtl/fu_handshake_chk.sv
module fu_handshake_chk #(
   parameter int unsigned NSRC     = 2,
   parameter int unsigned AW       = 5,
   parameter int unsigned DW       = 32,
   parameter int unsigned EXEC_CYC = 0
) (
   input logic               clk,
   input logic               rst,
   input logic               issue_i,
   input logic [NSRC*AW-1:0] src_addr_i,
   input logic               busy_o,
   input logic               rd_req_o,
   input logic               go_rd_i,
   input logic               rf_rd_en_o,
   input logic [NSRC*AW-1:0] rf_rd_addr_o,
   input logic [NSRC*DW-1:0] rf_rd_data_i,
   input logic               go_exec_o,
   input logic [NSRC*DW-1:0] opnd_o,
   input logic               wr_req_o,
   input logic               go_wr_i
);
   // R1
   reset_idle_chk: assert property (@(posedge clk)
      rst |=> (!busy_o && !rd_req_o && !go_exec_o && !wr_req_o && !rf_rd_en_o));

   // R2
   issue_take_chk: assert property (@(posedge clk) disable iff (rst)
      (!busy_o && issue_i) |=> (busy_o && rd_req_o && rf_rd_addr_o == $past(src_addr_i)));

   // R3
   addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
      busy_o |=> $stable(rf_rd_addr_o));

   // R4
   rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (rd_req_o && !go_rd_i) |=> rd_req_o);

   // R5
   rd_en_exec_chk: assert property (@(posedge clk) disable iff (rst)
      rf_rd_en_o |=> go_exec_o);

   // R6
   exec_follow_chk: assert property (@(posedge clk) disable iff (rst)
      (rd_req_o && go_rd_i) |=> go_exec_o);

   // R6
   exec_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      go_exec_o |=> !go_exec_o);

   // R7
   opnd_cap_chk: assert property (@(posedge clk) disable iff (rst)
      go_exec_o |=> (opnd_o == $past(rf_rd_data_i)));

   // R7
   opnd_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !go_exec_o |=> $stable(opnd_o));

   // R8
   wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_req_o && !go_wr_i) |=> wr_req_o);

   generate
      if (EXEC_CYC == 0) begin : g_min
         // R8
         wr_after_exec_chk: assert property (@(posedge clk) disable iff (rst)
            go_exec_o |=> wr_req_o);
      end
   endgenerate

   // R9
   wr_done_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_req_o && go_wr_i) |=> (!wr_req_o && !busy_o && !rd_req_o));

   // R10
   one_phase_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0({rd_req_o, go_exec_o, wr_req_o}));
endmodule

bind fu_handshake fu_handshake_chk #(
   .NSRC(NSRC), .AW(AW), .DW(DW), .EXEC_CYC(EXEC_CYC)
) u_chk (.*);

// File: tb/fu_handshake_test.sv
module fu_handshake_test;
   localparam int CLK_PERIOD = 10;
   localparam int NSRC = 2;
   localparam int AW   = 5;
   localparam int DW   = 32;

   logic               clk = 1'b0;
   logic               rst = 1'b1;
   logic               issue_i = 1'b0;
   logic [NSRC*AW-1:0] src_addr_i = '0;
   logic               busy_o, rd_req_o, rf_rd_en_o, go_exec_o, wr_req_o;
   logic               go_rd_i = 1'b0;
   logic               go_wr_i = 1'b0;
   logic [NSRC*AW-1:0] rf_rd_addr_o;
   logic [NSRC*DW-1:0] rf_rd_data_i;
   logic [NSRC*DW-1:0] opnd_o;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   fu_handshake #(.NSRC(NSRC), .AW(AW), .DW(DW)) uut (.*);

   function automatic logic [DW-1:0] rf_val(input logic [AW-1:0] a);
      return (DW'(a) * 32'h0101_3579) ^ 32'h5A5A_C3C3;
   endfunction

   // bench-side synchronous register file
   always_ff @(posedge clk) begin
      if (rf_rd_en_o)
         for (int k = 0; k < NSRC; k++)
            rf_rd_data_i[k*DW +: DW] <= rf_val(rf_rd_addr_o[k*AW +: AW]);
      else
         rf_rd_data_i <= '1;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   function automatic logic [NSRC*DW-1:0] exp_opnd(input logic [AW-1:0] a0,
                                                    input logic [AW-1:0] a1);
      return {rf_val(a1), rf_val(a0)};
   endfunction

   // runs one full operation, returning nothing; checks along the way
   task automatic run_op(input logic [AW-1:0] a0, input logic [AW-1:0] a1,
                         input int rd_wait, input int wr_wait);
      issue_i = 1'b1; src_addr_i = {a1, a0};
      step();
      issue_i = 1'b0;
      chk(busy_o && rd_req_o, "R2", "busy/rd_req after issue", {busy_o, rd_req_o}, 2'b11);
      for (int i = 0; i < rd_wait; i++) begin
         step();
         chk(rd_req_o && !go_exec_o, "R4", "rd_req held", rd_req_o, 1);
      end
      go_rd_i = 1'b1;
      #1;
      chk(rf_rd_en_o, "R5", "rf_rd_en on grant", rf_rd_en_o, 1);
      chk(rf_rd_addr_o == {a1, a0}, "R5", "rf address", rf_rd_addr_o, {a1, a0});
      step();
      go_rd_i = 1'b0;
      chk(go_exec_o && !rd_req_o, "R6", "go_exec after grant", go_exec_o, 1);
      chk($countones({rd_req_o, go_exec_o, wr_req_o}) == 1, "R10", "one phase",
          {rd_req_o, go_exec_o, wr_req_o}, 3'b010);
      step();
      chk(!go_exec_o, "R6", "go_exec single pulse", go_exec_o, 0);
      chk(wr_req_o, "R8", "wr_req after go_exec", wr_req_o, 1);
      chk(opnd_o == exp_opnd(a0, a1), "R7", "operands", opnd_o, exp_opnd(a0, a1));
      for (int i = 0; i < wr_wait; i++) begin
         step();
         chk(wr_req_o && busy_o, "R8", "wr_req held", wr_req_o, 1);
      end
      go_wr_i = 1'b1;
      step();
      go_wr_i = 1'b0;
      chk(!wr_req_o && !busy_o, "R9", "free after write grant", {busy_o, wr_req_o}, 0);
   endtask

   task automatic t_reset();
      rst = 1'b1;
      step(); step();
      chk(!busy_o && !rd_req_o && !go_exec_o && !wr_req_o && !rf_rd_en_o, "R1",
          "outputs in reset", {busy_o, rd_req_o, go_exec_o, wr_req_o, rf_rd_en_o}, 0);
      rst = 1'b0;
      step();
      chk(!busy_o, "R1", "idle after reset", busy_o, 0);
   endtask

   task automatic t_basic();
      run_op(5'd3, 5'd17, 2, 3);
   endtask

   task automatic t_stray_grants();
      go_rd_i = 1'b1; go_wr_i = 1'b1;
      #1;
      chk(!rf_rd_en_o, "R4", "no read enable when idle", rf_rd_en_o, 0);
      step();
      go_rd_i = 1'b0; go_wr_i = 1'b0;
      chk(!busy_o && !go_exec_o && !wr_req_o, "R9", "stray grants ignored",
          {busy_o, go_exec_o, wr_req_o}, 0);
   endtask

   task automatic t_busy_issue();
      issue_i = 1'b1; src_addr_i = {5'd9, 5'd4};
      step();
      src_addr_i = {5'd30, 5'd31};   // issue still high while busy
      step();
      issue_i = 1'b0;
      chk(rf_rd_addr_o == {5'd9, 5'd4}, "R3", "address kept while busy",
          rf_rd_addr_o, {5'd9, 5'd4});
      go_rd_i = 1'b1;
      step();
      go_rd_i = 1'b0;
      step();
      chk(opnd_o == exp_opnd(5'd4, 5'd9), "R7", "operands of first issue",
          opnd_o, exp_opnd(5'd4, 5'd9));
      // issue colliding with the write grant
      issue_i = 1'b1; go_wr_i = 1'b1; src_addr_i = {5'd1, 5'd2};
      step();
      issue_i = 1'b0; go_wr_i = 1'b0;
      chk(!busy_o && !rd_req_o, "R3", "issue at write grant ignored",
          {busy_o, rd_req_o}, 0);
      chk(rf_rd_addr_o == {5'd9, 5'd4}, "R3", "address not reloaded",
          rf_rd_addr_o, {5'd9, 5'd4});
   endtask

   task automatic t_back_to_back();
      run_op(5'd0, 5'd31, 0, 0);
      run_op(5'd12, 5'd7, 1, 0);
      step(); step();
      chk(opnd_o == exp_opnd(5'd12, 5'd7), "R7", "operands held when idle",
          opnd_o, exp_opnd(5'd12, 5'd7));
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_basic();
      t_stray_grants();
      t_busy_issue();
      t_back_to_back();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule